// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This block watches a 32-bit input port and turns pin activity into interrupts. Every bit is qualified by its own enable and direction, detected either as a level or as an edge with a chosen polarity, optionally cleaned by a glitch filter that runs on a slow filter clock, and brought into the system clock domain. Edge events are held in a small per-bit state machine until software clears them. The block exposes the unmasked status, the masked status and one combined interrupt line for the interrupt controller.

The per-bit edge holder has two states. `EDGE_IDLE` means no event is pending. The ARM transition moves a bit from `EDGE_IDLE` to `EDGE_HELD` when a qualified edge of the selected polarity is seen. The RELEASE transition moves it back to `EDGE_IDLE` on a clear pulse, or when the bit's enable is low. A clear and a new edge in the same cycle leave the bit in `EDGE_HELD`, so the new event is kept.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, with every configuration vector at zero, `raw_status`, `status` and `irq` are all zero.
- R2: A level-mode bit (`irq_edge`=0) with `lvl_sync`=0 follows the pin with no clock: `irq_pol`=1 reports the bit while the pin is 1, `irq_pol`=0 reports it while the pin is 0.
- R3: With `lvl_sync`=1, a level-mode bit follows the pin through two system clock flops: a pin change applied between edges shows up after the second rising edge of `clk`, not after the first.
- R4: An edge-mode bit (`irq_edge`=1) latches on a rising pin edge when `irq_pol`=1 and on a falling pin edge when `irq_pol`=0; the opposite edge is ignored. With the filter off, the status bit is set after the third rising `clk` edge following the pin change, and stays set after the pin returns.
- R5: A 1 on `edge_clr` for one cycle releases a held edge bit; `edge_clr` has no effect on a level-mode bit. When a clear and a new qualified edge fall in the same cycle, the bit stays set.
- R6: Driving a bit's `irq_en` low releases a held edge bit at the next `clk` edge, and it stays released after the enable returns if no new edge arrives.
- R7: A bit with `irq_en`=0 or `pin_dir_out`=1 raises no interrupt: its level status is 0 and no new edge is latched.
- R8: `status` is `raw_status` with every bit whose `irq_mask` bit is 1 forced to 0; `irq` is 1 exactly when any `status` bit is 1.
- R9: With `db_en` set for a bit, a pin pulse that covers only one rising edge of `db_clk` is dropped, and a pulse that covers two rising edges is accepted.
- R10: Changing `irq_pol` of an edge-mode bit while its pin is steady latches no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| db_clk | input | 1 | Slow clock of the glitch filter |
| pin_in | input | 32 | Pin values from the pads |
| irq_en | input | 32 | Per-bit interrupt enable |
| irq_mask | input | 32 | Per-bit mask, 1 blocks the bit from `status` and `irq` |
| irq_edge | input | 32 | Per-bit detection type, 0 level, 1 edge |
| irq_pol | input | 32 | Per-bit polarity, 0 low/falling, 1 high/rising |
| db_en | input | 32 | Per-bit glitch filter enable |
| lvl_sync | input | 1 | 1 routes level detection through the clock synchronizer |
| pin_dir_out | input | 32 | Per-bit direction, 1 marks the pin as output |
| edge_clr | input | 32 | Per-bit write-one pulse that releases a held edge |
| raw_status | output | 32 | Interrupt status before masking |
| status | output | 32 | Interrupt status after masking |
| irq | output | 1 | OR of all masked status bits |

## Verification
The bench aims at the exact latency of each path, counting flops: a level bit without synchronization must respond within the same cycle, one with synchronization after exactly two edges, an edge bit after exactly three; a design with a missing or extra flop fails those cycle checks. It races a clear against a fresh edge, where a design giving the clear priority would lose the event, and clears a level bit, where a wrongly wired clear would drop it. Glitch filtering is checked with pulses covering one and two filter clock edges, which catches a filter that is one stage short or long. Polarity flips on a steady pin catch a design that derives edges from the polarity-adjusted value.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    typedef enum logic {
        EDGE_IDLE = 1'b0,
        EDGE_HELD = 1'b1
    } edge_st_e;
endpackage

// File: rtl/gpio_db_filter.sv
// Glitch filter in the slow clock domain: two samples, output moves only
// when both samples agree.
module gpio_db_filter #(
    parameter int WIDTH = 32
) (
    input  logic             db_clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] filt_out
);
    logic [WIDTH-1:0] smp_a;
    logic [WIDTH-1:0] smp_b;
    logic [WIDTH-1:0] filt_q;

    always_ff @(posedge db_clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_a  <= '0;
            smp_b  <= '0;
            filt_q <= '0;
        end else begin
            smp_a  <= pin_in;
            smp_b  <= smp_a;
            filt_q <= (smp_a & smp_b) | (filt_q & (smp_a ^ smp_b));
        end
    end

    assign filt_out = filt_q;
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/gpio_edge_cell.sv
// One bit of edge holding: EDGE_IDLE --ARM--> EDGE_HELD --RELEASE--> EDGE_IDLE
module gpio_edge_cell
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    input  logic en,
    output logic held
);
    edge_st_e st_q;
    edge_st_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EDGE_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        held = 1'b0;
        unique case (st_q)
            EDGE_IDLE: begin
                if (hit) st_d = EDGE_HELD;             // ARM
            end
            EDGE_HELD: begin
                held = 1'b1;
                if (!en)              st_d = EDGE_IDLE; // RELEASE (disabled)
                else if (clr && !hit) st_d = EDGE_IDLE; // RELEASE (clear), new edge wins
            end
            default: st_d = EDGE_IDLE;
        endcase
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             db_clk,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] irq_en,
    input  logic [WIDTH-1:0] irq_mask,
    input  logic [WIDTH-1:0] irq_edge,
    input  logic [WIDTH-1:0] irq_pol,
    input  logic [WIDTH-1:0] db_en,
    input  logic             lvl_sync,
    input  logic [WIDTH-1:0] pin_dir_out,
    input  logic [WIDTH-1:0] edge_clr,
    output logic [WIDTH-1:0] raw_status,
    output logic [WIDTH-1:0] status,
    output logic             irq
);
    logic [WIDTH-1:0] filt;
    logic [WIDTH-1:0] src_sel;
    logic [WIDTH-1:0] v_sync;
    logic [WIDTH-1:0] v_prev;
    logic [WIDTH-1:0] qual;
    logic [WIDTH-1:0] edge_hit;
    logic [WIDTH-1:0] held;
    logic [WIDTH-1:0] lvl_src;
    logic [WIDTH-1:0] lvl_raw;

    gpio_db_filter #(.WIDTH(WIDTH)) u_filter (
        .db_clk  (db_clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .filt_out(filt)
    );

    assign src_sel = (db_en & filt) | (~db_en & pin_in);

    gpio_sync2 #(.WIDTH(WIDTH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (src_sel),
        .q    (v_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_prev <= '0;
        else        v_prev <= v_sync;
    end

    assign qual     = irq_en & ~pin_dir_out;
    // Edges come from the raw synchronized value, so a polarity change is no edge.
    assign edge_hit = qual & irq_edge &
                      ((irq_pol & v_sync & ~v_prev) | (~irq_pol & ~v_sync & v_prev));

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_edge
            gpio_edge_cell u_cell (
                .clk  (clk),
                .rst_n(rst_n),
                .hit  (edge_hit[gi]),
                .clr  (edge_clr[gi]),
                .en   (irq_en[gi]),
                .held (held[gi])
            );
        end
    endgenerate

    assign lvl_src    = lvl_sync ? v_sync : src_sel;
    assign lvl_raw    = qual & ~irq_edge & ~(lvl_src ^ irq_pol);
    assign raw_status = (irq_edge & held) | lvl_raw;
    assign status     = raw_status & ~irq_mask;
    assign irq        = |status;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] irq_en,
    input logic [WIDTH-1:0] irq_mask,
    input logic [WIDTH-1:0] irq_edge,
    input logic [WIDTH-1:0] pin_dir_out,
    input logic [WIDTH-1:0] edge_clr,
    input logic [WIDTH-1:0] raw_status,
    input logic [WIDTH-1:0] status,
    input logic             irq
);
    logic started;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    // R8
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & irq_mask) == '0) && ((status & ~raw_status) == '0));

    // R8
    irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (status != '0));

    // R7
    out_dir_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_status & ~irq_edge & (pin_dir_out | ~irq_en)) == '0);

    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (($past(raw_status & irq_edge & irq_en & ~edge_clr)
                      & irq_edge & irq_en & ~raw_status) == '0));

    // R6
    disabled_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> ((raw_status & irq_edge & ~irq_en & $past(~irq_en)) == '0));
endmodule

bind gpio_irq_detect gpio_irq_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_en     (irq_en),
    .irq_mask   (irq_mask),
    .irq_edge   (irq_edge),
    .pin_dir_out(pin_dir_out),
    .edge_clr   (edge_clr),
    .raw_status (raw_status),
    .status     (status),
    .irq        (irq)
);

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         db_clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] irq_en = '0;
    logic [W-1:0] irq_mask = '0;
    logic [W-1:0] irq_edge = '0;
    logic [W-1:0] irq_pol = '0;
    logic [W-1:0] db_en = '0;
    logic         lvl_sync = 1'b0;
    logic [W-1:0] pin_dir_out = '0;
    logic [W-1:0] edge_clr = '0;
    logic [W-1:0] raw_status;
    logic [W-1:0] status;
    logic         irq;

    int vectors = 0;
    int miss = 0;

    gpio_irq_detect #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .db_clk(db_clk), .pin_in(pin_in),
        .irq_en(irq_en), .irq_mask(irq_mask), .irq_edge(irq_edge),
        .irq_pol(irq_pol), .db_en(db_en), .lvl_sync(lvl_sync),
        .pin_dir_out(pin_dir_out), .edge_clr(edge_clr),
        .raw_status(raw_status), .status(status), .irq(irq)
    );

    always #4 clk = ~clk;
    initial begin
        #3;
        forever #20 db_clk = ~db_clk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 raw", raw_status, '0);
        chk("R1 status", status, '0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_level_nosync();
        irq_en[0] = 1'b1; irq_pol[0] = 1'b1; lvl_sync = 1'b0;
        pin_in[0] = 1'b1; #1;
        chk("R2 high follows", {31'b0, raw_status[0]}, 32'd1);
        pin_in[0] = 1'b0; #1;
        chk("R2 high drops", {31'b0, raw_status[0]}, 32'd0);
        irq_pol[0] = 1'b0; #1;
        chk("R2 low active", {31'b0, raw_status[0]}, 32'd1);
        irq_en[0] = 1'b0; irq_pol[0] = 1'b1;
        step(1);
    endtask

    task automatic t_level_sync();
        irq_en[1] = 1'b1; irq_pol[1] = 1'b1; lvl_sync = 1'b1;
        step(3);
        pin_in[1] = 1'b1;
        step(1);
        chk("R3 not after one edge", {31'b0, raw_status[1]}, 32'd0);
        step(1);
        chk("R3 after two edges", {31'b0, raw_status[1]}, 32'd1);
        pin_in[1] = 1'b0; irq_en[1] = 1'b0; lvl_sync = 1'b0;
        step(3);
    endtask

    task automatic t_edge_rise();
        irq_en[2] = 1'b1; irq_edge[2] = 1'b1; irq_pol[2] = 1'b1;
        step(2);
        pin_in[2] = 1'b1;
        step(2);
        chk("R4 rise not yet", {31'b0, raw_status[2]}, 32'd0);
        step(1);
        chk("R4 rise latched", {31'b0, raw_status[2]}, 32'd1);
        pin_in[2] = 1'b0;
        step(5);
        chk("R4 rise held", {31'b0, raw_status[2]}, 32'd1);
        edge_clr[2] = 1'b1;
        step(1);
        edge_clr[2] = 1'b0;
        chk("R5 clear releases", {31'b0, raw_status[2]}, 32'd0);
    endtask

    task automatic t_edge_fall();
        irq_en[3] = 1'b1; irq_edge[3] = 1'b1; irq_pol[3] = 1'b0;
        pin_in[3] = 1'b1;
        step(5);
        chk("R4 rise ignored in falling mode", {31'b0, raw_status[3]}, 32'd0);
        pin_in[3] = 1'b0;
        step(2);
        chk("R4 fall not yet", {31'b0, raw_status[3]}, 32'd0);
        step(1);
        chk("R4 fall latched", {31'b0, raw_status[3]}, 32'd1);
        edge_clr[3] = 1'b1;
        step(1);
        edge_clr[3] = 1'b0;
        irq_en[3] = 1'b0;
        step(1);
    endtask

    task automatic t_clr_level();
        irq_en[0] = 1'b1; irq_pol[0] = 1'b1; pin_in[0] = 1'b1;
        edge_clr[0] = 1'b1;
        step(1);
        edge_clr[0] = 1'b0; #1;
        chk("R5 clear ignored on level", {31'b0, raw_status[0]}, 32'd1);
        pin_in[0] = 1'b0; irq_en[0] = 1'b0;
        step(1);
    endtask

    task automatic t_clear_race();
        pin_in[2] = 1'b1;
        step(3);
        pin_in[2] = 1'b0;
        step(4);
        chk("R5 held before race", {31'b0, raw_status[2]}, 32'd1);
        pin_in[2] = 1'b1;
        step(2);
        edge_clr[2] = 1'b1;
        step(1);
        edge_clr[2] = 1'b0;
        chk("R5 new edge beats clear", {31'b0, raw_status[2]}, 32'd1);
    endtask

    task automatic t_disable();
        irq_en[2] = 1'b0;
        step(1);
        chk("R6 disable releases", {31'b0, raw_status[2]}, 32'd0);
        irq_en[2] = 1'b1;
        step(3);
        chk("R6 stays released", {31'b0, raw_status[2]}, 32'd0);
    endtask

    task automatic t_pol_change();
        irq_pol[2] = 1'b0;
        step(4);
        chk("R10 polarity flip no event", {31'b0, raw_status[2]}, 32'd0);
        irq_pol[2] = 1'b1;
        step(4);
        chk("R10 polarity flip back no event", {31'b0, raw_status[2]}, 32'd0);
        pin_in[2] = 1'b0;
        step(4);
    endtask

    task automatic t_dir();
        irq_en[0] = 1'b1; irq_pol[0] = 1'b1; pin_in[0] = 1'b1; #1;
        chk("R7 level before dir", {31'b0, raw_status[0]}, 32'd1);
        pin_dir_out[0] = 1'b1; #1;
        chk("R7 output dir level blocked", {31'b0, raw_status[0]}, 32'd0);
        pin_dir_out[2] = 1'b1;
        pin_in[2] = 1'b1;
        step(5);
        chk("R7 output dir edge blocked", {31'b0, raw_status[2]}, 32'd0);
        pin_dir_out = '0;
        irq_en[2] = 1'b0;
        pin_in[2] = 1'b0;
        irq_en[5] = 1'b0; irq_pol[5] = 1'b1; pin_in[5] = 1'b1; #1;
        chk("R7 disabled bit quiet", {31'b0, raw_status[5]}, 32'd0);
        pin_in[5] = 1'b0;
        step(4);
    endtask

    task automatic t_mask();
        chk("R8 only bit0 raw", raw_status, 32'h1);
        irq_mask[0] = 1'b1; #1;
        chk("R8 masked status", status, 32'h0);
        chk("R8 masked irq", {31'b0, irq}, 32'd0);
        chk("R8 raw unmasked", raw_status, 32'h1);
        irq_en[6] = 1'b1; irq_pol[6] = 1'b0; #1;
        chk("R8 other bit drives irq", {31'b0, irq}, 32'd1);
        chk("R8 status pattern", status, 32'h40);
        irq_mask[0] = 1'b0; #1;
        chk("R8 unmasked status", status, 32'h41);
        irq_en[6] = 1'b0; irq_en[0] = 1'b0; pin_in[0] = 1'b0; #1;
        chk("R8 irq drops", {31'b0, irq}, 32'd0);
        step(1);
    endtask

    task automatic t_debounce();
        irq_en[4] = 1'b1; irq_edge[4] = 1'b1; irq_pol[4] = 1'b1; db_en[4] = 1'b1;
        repeat (4) @(posedge db_clk);
        #2 pin_in[4] = 1'b1;
        @(posedge db_clk);
        #2 pin_in[4] = 1'b0;
        repeat (6) @(posedge db_clk);
        @(negedge clk);
        chk("R9 one-edge pulse dropped", {31'b0, raw_status[4]}, 32'd0);
        @(posedge db_clk);
        #2 pin_in[4] = 1'b1;
        repeat (2) @(posedge db_clk);
        #2 pin_in[4] = 1'b0;
        repeat (6) @(posedge db_clk);
        @(negedge clk);
        chk("R9 two-edge pulse accepted", {31'b0, raw_status[4]}, 32'd1);
    endtask

    initial begin
        #200_000;
        miss++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_level_nosync();
        t_level_sync();
        t_edge_rise();
        t_edge_fall();
        t_clr_level();
        t_clear_race();
        t_disable();
        t_pol_change();
        t_dir();
        irq_en[0] = 1'b1; irq_pol[0] = 1'b1; pin_in[0] = 1'b1; #1;
        t_mask();
        t_debounce();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end
endmodule